// File: doc/BRIEF.md
# Compressed Branch-on-Zero Resolver

This unit decodes and resolves a 16-bit compressed conditional branch in a single combinational step. The branch tests one register against zero. The fetch stage supplies the instruction parcel and the current pc. The register file supplies the value of the register that the parcel names. A control input reports whether the compressed extension is enabled.

The unit recognises the parcel and extracts the 3-bit compact register field. It gathers the offset bits, which the format scatters across the parcel, and sign-extends the result. It then decides whether the branch is taken and selects the next pc. It also produces the equivalent 32-bit branch-if-equal word, which compares the register with x0, so that later stages can handle the branch as an ordinary full-width instruction.

Two exception flags go to the trap logic. The illegal-instruction flag marks the branch when the compressed extension is built in but currently switched off. The misaligned-target flag marks a taken branch whose target is not 4-byte aligned while compressed fetch is not in effect. The instruction has no privilege-mode restriction, so no mode input exists.

Top module: `cbz_resolver`

## Requirements
- R1: The parcel is recognised, and `instValid` is high, only when bits 1:0 are `01` and bits 15:13 are `110`. For any other parcel, `instValid`, `branchTaken`, `illegalInst` and `misalignedTarget` are all low, `expandedWord` is zero and `nextPc` is pc+2.
- R2: The offset bits 8:1 are built from parcel bits in this order, most significant first: 12, 6:5, 2, 11:10, 4:3. Offset bit 0 is zero. The 9-bit offset is sign-extended and added to the pc to form the target.
- R3: `regIndex` is 8 plus parcel bits 9:7, which addresses x8 to x15.
- R4: A recognised branch with no exception is taken only when `regValue` is zero. A taken branch sets `nextPc` to the target. A branch that is not taken sets `nextPc` to pc+2.
- R5: For a recognised parcel, `expandedWord` is the 32-bit branch-if-equal of the register against x0. The opcode is `1100011`, funct3 is `000` and rs2 is 0. Offset bits 12, 10:5, 4:1 and 11 go to word bits 31, 30:25, 11:8 and 7.
- R6: When `EXT_IMPLEMENTED` is 1 and `extEnabled` is 0, a recognised parcel raises `illegalInst`, is not taken and sets `nextPc` to the pc.
- R7: A taken branch whose target has bit 1 set raises `misalignedTarget` when the compressed extension is not in effect (not implemented, or disabled). In that case it is not taken and `nextPc` stays at the pc. When the extension is in effect, bit 1 of the target raises nothing.
- R8: The reach of the branch runs from -256 to +254 bytes around the pc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrParcel | input | 16 | Compressed instruction parcel |
| pcIn | input | XLEN | Address of the parcel |
| regValue | input | XLEN | Value of the register named by `regIndex` |
| extEnabled | input | 1 | Compressed extension currently enabled |
| instValid | output | 1 | Parcel is the compressed branch-on-zero |
| regIndex | output | 5 | Architectural register number (x8 to x15) |
| branchTaken | output | 1 | Branch redirects the pc |
| nextPc | output | XLEN | pc after this instruction |
| expandedWord | output | 32 | Equivalent full-width branch word |
| illegalInst | output | 1 | Illegal-instruction exception |
| misalignedTarget | output | 1 | Instruction-address-misaligned exception |

## Verification
The inline assertions watch structural invariants on every evaluation:
- The two exception flags are never high together.
- An exception never appears on an unrecognised parcel and never appears alongside a taken branch.
- An exception always holds the pc.
- The register number always lies in x8 to x15.
- A recognised, untaken and exception-free branch always falls through to pc+2.

Only the bench scenarios can show the numeric behaviour:
- The offset bits are gathered in the right order, reaching both ends of the range.
- The expanded word encodes the correct fields.
- Zero and nonzero operands decide the branch correctly.
- Each exception appears under exactly the extension and alignment conditions given in R6 and R7.

// File: rtl/cbz_pkg.sv
package cbz_pkg;

  typedef enum logic [1:0] {
    NEXT_SEQ    = 2'd0,
    NEXT_TARGET = 2'd1,
    NEXT_HOLD   = 2'd2
  } nextSel_e;

  typedef struct packed {
    logic     instValid;
    logic     branchTaken;
    logic     raiseIllegal;
    logic     raiseMisalign;
    nextSel_e nextSel;
  } ctrlStrobes_t;

  localparam logic [6:0] BRANCH_OPCODE = 7'b1100011;
  localparam logic [2:0] BEQ_FUNCT3    = 3'b000;
  localparam int unsigned OFFSET_BITS  = 9;

endpackage

// File: rtl/cbz_control.sv
module cbz_control
  import cbz_pkg::*;
#(
  parameter bit EXT_IMPLEMENTED = 1'b1
) (
  input  logic [15:0]  instrParcel,
  input  logic         extEnabled,
  input  logic         operandZero,
  input  logic         targetBit1,
  output ctrlStrobes_t strobes
);

  logic parcelMatch;
  logic compressedOn;
  logic wantBranch;

  always_comb begin
    parcelMatch  = (instrParcel[1:0] == 2'b01) && (instrParcel[15:13] == 3'b110);
    compressedOn = EXT_IMPLEMENTED && extEnabled;
    wantBranch   = parcelMatch && operandZero;

    strobes               = '0;
    strobes.nextSel       = NEXT_SEQ;
    strobes.instValid     = parcelMatch;

    if (parcelMatch) begin
      if (EXT_IMPLEMENTED && !extEnabled) begin
        strobes.raiseIllegal = 1'b1;
        strobes.nextSel      = NEXT_HOLD;
      end else if (wantBranch && targetBit1 && !compressedOn) begin
        strobes.raiseMisalign = 1'b1;
        strobes.nextSel       = NEXT_HOLD;
      end else if (wantBranch) begin
        strobes.branchTaken = 1'b1;
        strobes.nextSel     = NEXT_TARGET;
      end
    end
  end

  always_comb begin
    AST_EXC_EXCLUSIVE: assert (!(strobes.raiseIllegal && strobes.raiseMisalign)); // R6
    AST_EXC_NEEDS_VALID: assert (!(strobes.raiseIllegal || strobes.raiseMisalign)
                                 || strobes.instValid); // R1
    AST_TAKEN_NO_EXC: assert (!(strobes.branchTaken
                                && (strobes.raiseIllegal || strobes.raiseMisalign))); // R4
  end

endmodule

// File: rtl/cbz_datapath.sv
module cbz_datapath
  import cbz_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [15:0]     instrParcel,
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] regValue,
  input  ctrlStrobes_t    strobes,
  output logic            operandZero,
  output logic            targetBit1,
  output logic [4:0]      regIndex,
  output logic [XLEN-1:0] nextPc,
  output logic [31:0]     expandedWord
);

  localparam int unsigned EXT_BITS = XLEN - OFFSET_BITS;
  localparam logic [XLEN-1:0] PARCEL_STEP = XLEN'(2);

  logic [OFFSET_BITS-1:0] branchOffset;
  logic [XLEN-1:0]        offsetWide;
  logic [XLEN-1:0]        branchTarget;
  logic [12:0]            fullImm;
  logic [31:0]            rawWord;

  always_comb begin
    branchOffset = {instrParcel[12], instrParcel[6:5], instrParcel[2],
                    instrParcel[11:10], instrParcel[4:3], 1'b0};
    offsetWide   = {{EXT_BITS{branchOffset[OFFSET_BITS-1]}}, branchOffset};
    branchTarget = pcIn + offsetWide;
    regIndex     = {2'b01, instrParcel[9:7]};
    operandZero  = (regValue == '0);
    targetBit1   = branchTarget[1];
  end

  always_comb begin
    fullImm = {{(13-OFFSET_BITS){branchOffset[OFFSET_BITS-1]}}, branchOffset};
    rawWord = {fullImm[12], fullImm[10:5], 5'd0, regIndex, BEQ_FUNCT3,
               fullImm[4:1], fullImm[11], BRANCH_OPCODE};
    expandedWord = strobes.instValid ? rawWord : 32'd0;
  end

  always_comb begin
    unique case (strobes.nextSel)
      NEXT_TARGET: nextPc = branchTarget;
      NEXT_HOLD:   nextPc = pcIn;
      default:     nextPc = pcIn + PARCEL_STEP;
    endcase
  end

  always_comb begin
    AST_REG_RANGE: assert (regIndex >= 5'd8 && regIndex <= 5'd15); // R3
    AST_WORD_RS2_ZERO: assert (expandedWord[24:20] == 5'd0); // R5
  end

endmodule

// File: rtl/cbz_resolver.sv
module cbz_resolver
  import cbz_pkg::*;
#(
  parameter int unsigned XLEN            = 32,
  parameter bit          EXT_IMPLEMENTED = 1'b1
) (
  input  logic [15:0]     instrParcel,
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] regValue,
  input  logic            extEnabled,
  output logic            instValid,
  output logic [4:0]      regIndex,
  output logic            branchTaken,
  output logic [XLEN-1:0] nextPc,
  output logic [31:0]     expandedWord,
  output logic            illegalInst,
  output logic            misalignedTarget
);

  ctrlStrobes_t strobes;
  logic         operandZero;
  logic         targetBit1;

  cbz_control #(
    .EXT_IMPLEMENTED(EXT_IMPLEMENTED)
  ) u_control (
    .instrParcel(instrParcel),
    .extEnabled (extEnabled),
    .operandZero(operandZero),
    .targetBit1 (targetBit1),
    .strobes    (strobes)
  );

  cbz_datapath #(
    .XLEN(XLEN)
  ) u_datapath (
    .instrParcel (instrParcel),
    .pcIn        (pcIn),
    .regValue    (regValue),
    .strobes     (strobes),
    .operandZero (operandZero),
    .targetBit1  (targetBit1),
    .regIndex    (regIndex),
    .nextPc      (nextPc),
    .expandedWord(expandedWord)
  );

  assign instValid        = strobes.instValid;
  assign branchTaken      = strobes.branchTaken;
  assign illegalInst      = strobes.raiseIllegal;
  assign misalignedTarget = strobes.raiseMisalign;

  always_comb begin
    AST_EXC_HOLDS_PC: assert (!(illegalInst || misalignedTarget) || nextPc == pcIn); // R7
    AST_FALLTHROUGH: assert (!(instValid && !branchTaken && !illegalInst && !misalignedTarget)
                             || nextPc == pcIn + XLEN'(2)); // R4
  end

endmodule

// File: tb/cbz_resolver_bench.sv
module cbz_resolver_bench;

  localparam int unsigned XLEN       = 32;
  localparam time         CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [15:0]     instrParcel;
  logic [XLEN-1:0] pcIn;
  logic [XLEN-1:0] regValue;
  logic            extEnabled;

  logic            aValid, aTaken, aIll, aMis;
  logic [4:0]      aReg;
  logic [XLEN-1:0] aNext;
  logic [31:0]     aWord;
  logic            bValid, bTaken, bIll, bMis;
  logic [4:0]      bReg;
  logic [XLEN-1:0] bNext;
  logic [31:0]     bWord;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbz_resolver #(.XLEN(XLEN), .EXT_IMPLEMENTED(1'b1)) u_cbz_resolver (
    .instrParcel(instrParcel), .pcIn(pcIn), .regValue(regValue), .extEnabled(extEnabled),
    .instValid(aValid), .regIndex(aReg), .branchTaken(aTaken), .nextPc(aNext),
    .expandedWord(aWord), .illegalInst(aIll), .misalignedTarget(aMis)
  );

  cbz_resolver #(.XLEN(XLEN), .EXT_IMPLEMENTED(1'b0)) u_cbz_resolver_noext (
    .instrParcel(instrParcel), .pcIn(pcIn), .regValue(regValue), .extEnabled(extEnabled),
    .instValid(bValid), .regIndex(bReg), .branchTaken(bTaken), .nextPc(bNext),
    .expandedWord(bWord), .illegalInst(bIll), .misalignedTarget(bMis)
  );

  function automatic logic [15:0] encodeParcel(input logic [8:0] off, input logic [2:0] rs);
    logic [15:0] p;
    p = 16'd0;
    p[15:13] = 3'b110;
    p[1:0]   = 2'b01;
    p[12]    = off[8];
    p[6:5]   = off[7:6];
    p[2]     = off[5];
    p[11:10] = off[4:3];
    p[4:3]   = off[2:1];
    p[9:7]   = rs;
    return p;
  endfunction

  function automatic logic [31:0] beqWord(input logic [8:0] off, input logic [2:0] rs);
    logic [12:0] im;
    logic [31:0] w;
    im = {{4{off[8]}}, off};
    w = 32'd0;
    w[6:0]   = 7'b1100011;
    w[7]     = im[11];
    w[11:8]  = im[4:1];
    w[14:12] = 3'b000;
    w[19:15] = {2'b01, rs};
    w[24:20] = 5'd0;
    w[30:25] = im[10:5];
    w[31]    = im[12];
    return w;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] p, input logic [31:0] pc, input logic [31:0] rv,
                       input logic en);
    @(negedge clk);
    instrParcel = p;
    pcIn        = pc;
    regValue    = rv;
    extEnabled  = en;
    #(CLK_PERIOD/4);
  endtask

  task automatic testIdle();
    apply(16'h0000, 32'h0000_0100, 32'd0, 1'b1);
    check("R1", "valid", 32'(aValid), 32'd0);
    check("R1", "exceptions", 32'({aIll, aMis}), 32'd0);
    check("R1", "nextPc", aNext, 32'h0000_0102);
    check("R1", "word", aWord, 32'd0);
    apply(encodeParcel(9'd8, 3'd0) | 16'h0002, 32'h200, 32'd0, 1'b0);
    check("R1", "bits1:0=11 valid", 32'({aValid, aIll, aTaken}), 32'd0);
    apply(encodeParcel(9'd8, 3'd0) | 16'h2000, 32'h200, 32'd0, 1'b0);
    check("R1", "bits15:13=111 valid", 32'({aValid, aIll, aTaken}), 32'd0);
    check("R1", "nextPc on other parcel", aNext, 32'h202);
  endtask

  task automatic testMaxForward();
    apply(encodeParcel(9'h0FE, 3'd5), 32'h0000_1000, 32'd0, 1'b1);
    check("R1", "valid", 32'(aValid), 32'd1);
    check("R4", "taken", 32'(aTaken), 32'd1);
    check("R8", "target +254", aNext, 32'h0000_10FE);
    check("R3", "regIndex", 32'(aReg), 32'd13);
    check("R5", "word", aWord, beqWord(9'h0FE, 3'd5));
  endtask

  task automatic testMaxBackward();
    apply(encodeParcel(9'h100, 3'd0), 32'h0000_2000, 32'd0, 1'b1);
    check("R8", "target -256", aNext, 32'h0000_1F00);
    check("R3", "regIndex x8", 32'(aReg), 32'd8);
    check("R5", "word -256", aWord, 32'hF004_00E3);
  endtask

  task automatic testScatter();
    apply(encodeParcel(9'h0AA, 3'd7), 32'h0000_4000, 32'd0, 1'b1);
    check("R2", "offset 0xAA", aNext, 32'h0000_40AA);
    check("R3", "regIndex x15", 32'(aReg), 32'd15);
    apply(encodeParcel(9'h154, 3'd2), 32'h0000_4000, 32'd0, 1'b1);
    check("R2", "offset -0xAC", aNext, 32'h0000_3F54);
    check("R5", "word", aWord, beqWord(9'h154, 3'd2));
  endtask

  task automatic testNotTaken();
    apply(encodeParcel(9'h040, 3'd1), 32'h0000_3000, 32'h0000_0001, 1'b1);
    check("R4", "not taken", 32'(aTaken), 32'd0);
    check("R4", "fallthrough", aNext, 32'h0000_3002);
    apply(encodeParcel(9'h040, 3'd1), 32'h0000_3000, 32'h8000_0000, 1'b1);
    check("R4", "msb-only operand", aNext, 32'h0000_3002);
  endtask

  task automatic testIllegal();
    apply(encodeParcel(9'h010, 3'd3), 32'h0000_5000, 32'd0, 1'b0);
    check("R6", "illegal", 32'(aIll), 32'd1);
    check("R6", "not taken", 32'(aTaken), 32'd0);
    check("R6", "pc held", aNext, 32'h0000_5000);
    check("R6", "no illegal when absent", 32'(bIll), 32'd0);
  endtask

  task automatic testMisalign();
    apply(encodeParcel(9'h006, 3'd4), 32'h0000_1000, 32'd0, 1'b0);
    check("R7", "misaligned", 32'(bMis), 32'd1);
    check("R7", "pc held", bNext, 32'h0000_1000);
    check("R7", "not taken", 32'(bTaken), 32'd0);
    apply(encodeParcel(9'h004, 3'd4), 32'h0000_1000, 32'd0, 1'b0);
    check("R7", "aligned taken", 32'({bTaken, bMis}), 32'b10);
    check("R7", "aligned target", bNext, 32'h0000_1004);
    apply(encodeParcel(9'h006, 3'd4), 32'h0000_1000, 32'h5, 1'b0);
    check("R7", "untaken no misalign", 32'(bMis), 32'd0);
    apply(encodeParcel(9'h006, 3'd4), 32'h0000_1000, 32'd0, 1'b1);
    check("R7", "enabled no misalign", 32'(aMis), 32'd0);
    check("R7", "enabled target", aNext, 32'h0000_1006);
  endtask

  initial begin
    instrParcel = '0;
    pcIn        = '0;
    regValue    = '0;
    extEnabled  = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testIdle();
    testMaxForward();
    testMaxBackward();
    testScatter();
    testNotTaken();
    testIllegal();
    testMisalign();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule